// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive side of an I2C-bus target. It watches the synchronised SCL and SDA lines for START and STOP conditions. It treats the first byte after every START as the address frame. When the seven address bits equal the programmed own address and the direction bit asks for a write, the engine joins the transfer. It then shifts in data bytes MSB first and hands each one to the host through a receive data register and a receive-full flag.

The host sets the acknowledge level that the engine drives during the ninth clock of each byte. The engine samples that level once per frame, so a change the host makes partway through a byte only applies to the next byte. If a new byte reaches its eighth falling SCL edge while the host has not yet read the previous byte, the engine holds SCL low until the host reads. The bus outputs are open-drain enables that pull a line low; the engine never drives a line high. A STOP sets a flag that the host can read and clear.

Top module: `i2c_rx_target`

## Requirements
- R1: While `rx_enable` is 0, both drive enables, `rx_full`, `stop_seen` and `rx_data` are 0 from the next clock on, and bus traffic has no effect.
- R2: An address frame whose upper seven bits equal `own_addr` and whose last bit is 0 (write) is acknowledged, and it loads `rx_data` with the whole address byte and sets `rx_full`. The host discards that byte with a dummy read.
- R3: An address frame with a different address, or with the last bit 1 (read), is not acknowledged: SDA is never pulled and `rx_full` stays 0. Every later byte is ignored until the next START.
- R4: In a joined transfer, each data byte is shifted in MSB first. It appears on `rx_data`, with `rx_full` set, a few clocks after the ninth SCL rising edge.
- R5: From the eighth SCL falling edge until the ninth falling edge, `sda_drive_low` equals the inverse of the acknowledge level (0 = acknowledge, 1 = no acknowledge). That level is `ack_level` as sampled at the first SCL rising edge of the same byte, so a change made later in the byte applies only from the next byte.
- R6: If `rx_full` is 1 at the eighth SCL falling edge of a byte, `scl_drive_low` is asserted and held until `rd_strobe`. If `rx_full` is 0 at that edge, SCL is not held.
- R7: A one-cycle `rd_strobe` clears `rx_full`. A strobe during a stretch also releases SCL.
- R8: A STOP (SDA rising while SCL is high) sets `stop_seen`, releases both lines and returns the engine to waiting for a START. `stop_clear` clears `stop_seen`.
- R9: A START that arrives partway through a byte discards the partial byte and begins a fresh address frame.
- R10: `sda_drive_low` only becomes active while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Transfer enable; 0 holds the engine inactive |
| own_addr | input | 7 | Own 7-bit target address |
| ack_level | input | 1 | Acknowledge level for the ninth clock (0 = ACK) |
| rd_strobe | input | 1 | Host read of the receive data register (one cycle) |
| stop_clear | input | 1 | Clears the stop flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (stretch) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive-full flag |
| stop_seen | output | 1 | STOP detected flag |

## Verification
The assertions assume that the bus master changes SDA only while SCL is low, except for START and STOP. They also assume that each SCL phase lasts well beyond the synchroniser latency, and that the host never reads in the same cycle as a ninth rising edge. The bench master keeps SDA stable for the whole high phase and uses 16-clock SCL phases. It issues host reads either between bytes or during a stretch, when SCL cannot rise.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = BYTE_W - 1;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rx_phase_t;

    typedef struct packed {
        rx_phase_t         phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] data;
        logic              full;
        logic              stop;
        logic              ack_lat;
        logic              scl_lo;
        logic              sda_lo;
    } rx_state_t;

    localparam rx_state_t RX_RESET = '{
        phase:   ST_IDLE,
        bit_cnt: '0,
        shreg:   '0,
        data:    '0,
        full:    1'b0,
        stop:    1'b0,
        ack_lat: 1'b0,
        scl_lo:  1'b0,
        sda_lo:  1'b0
    };
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_i;
            sda_p_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_p_q;
    assign scl_fall_o = ~scl_i & scl_p_q;
    assign start_o    = scl_i & scl_p_q & sda_p_q & ~sda_i;
    assign stop_o     = scl_i & scl_p_q & ~sda_p_q & sda_i;
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
    import i2c_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_level,
    input  logic              rd_strobe,
    input  logic              stop_clear,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              stop_seen
);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W + 1);

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, bus_start, bus_stop;
    rx_state_t  st_d, st_q;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in, sda_in}),
        .sync_o (line_s)
    );

    i2c_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (line_s[1]),
        .sda_i      (line_s[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    always_comb begin
        st_d = st_q;

        // host side: read clears the flag and ends any stretch
        if (rd_strobe) begin
            st_d.full   = 1'b0;
            st_d.scl_lo = 1'b0;
        end
        if (stop_clear) st_d.stop = 1'b0;

        if (st_q.phase == ST_ADDR || st_q.phase == ST_DATA) begin
            if (scl_rise) begin
                if (st_q.bit_cnt < CNT_ACK) begin
                    st_d.shreg   = {st_q.shreg[BYTE_W-2:0], line_s[0]};
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    if (st_q.bit_cnt == '0) st_d.ack_lat = ack_level;
                end else if (st_q.bit_cnt == CNT_ACK) begin
                    // ninth rising edge: hand the byte over (set beats clear)
                    st_d.data    = st_q.shreg;
                    st_d.full    = 1'b1;
                    st_d.bit_cnt = CNT_LAST;
                end
            end
            if (scl_fall) begin
                if (st_q.bit_cnt == CNT_ACK) begin
                    if (st_q.phase == ST_ADDR &&
                        (st_q.shreg[BYTE_W-1:1] != own_addr || st_q.shreg[0])) begin
                        st_d.phase = ST_SKIP;
                    end else begin
                        st_d.sda_lo = ~st_q.ack_lat;
                        st_d.scl_lo = st_q.full & ~rd_strobe;
                    end
                end else if (st_q.bit_cnt == CNT_LAST) begin
                    st_d.sda_lo  = 1'b0;
                    st_d.bit_cnt = '0;
                    st_d.phase   = ST_DATA;
                end
            end
        end

        if (bus_start) begin
            st_d.phase   = ST_ADDR;
            st_d.bit_cnt = '0;
            st_d.shreg   = '0;
            st_d.scl_lo  = 1'b0;
            st_d.sda_lo  = 1'b0;
        end
        if (bus_stop) begin
            st_d.phase   = ST_IDLE;
            st_d.bit_cnt = '0;
            st_d.scl_lo  = 1'b0;
            st_d.sda_lo  = 1'b0;
            st_d.stop    = 1'b1;
        end

        if (!rx_enable) st_d = RX_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_RESET;
        else        st_q <= st_d;
    end

    assign scl_drive_low = st_q.scl_lo;
    assign sda_drive_low = st_q.sda_lo;
    assign rx_data       = st_q.data;
    assign rx_full       = st_q.full;
    assign stop_seen     = st_q.stop;
endmodule

// File: rtl/i2c_rx_target_chk.sv
module i2c_rx_target_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic rd_strobe,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic rx_full,
    input logic stop_seen
);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!scl_drive_low && !sda_drive_low && !rx_full && !stop_seen));

    p_stretch_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> rx_full);

    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && scl_drive_low && !rd_strobe) |=> scl_drive_low);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rd_strobe && scl_drive_low) |=> (!rx_full && !scl_drive_low));

    p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (!scl_drive_low && !sda_drive_low));

    p_sda_only_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_in);
endmodule

bind i2c_rx_target i2c_rx_target_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enable     (rx_enable),
    .rd_strobe     (rd_strobe),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .rx_full       (rx_full),
    .stop_seen     (stop_seen)
);

// File: tb/i2c_rx_target_tb.sv
module i2c_rx_target_tb;
    localparam int H = 16;
    localparam logic [6:0] MY_ADDR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       ack_level = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       stop_clear = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_in, sda_in;
    logic       scl_drive_low, sda_drive_low, rx_full, stop_seen;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int mon_err_r1 = 0;
    int mon_err_r10 = 0;
    bit stretch_seen;
    logic [7:0] stretch_data;
    bit acked;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_in = m_scl & ~scl_drive_low;
    assign sda_in = m_sda & ~sda_drive_low;

    i2c_rx_target u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .own_addr(MY_ADDR),
        .ack_level(ack_level), .rd_strobe(rd_strobe), .stop_clear(stop_clear),
        .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .rx_data(rx_data), .rx_full(rx_full),
        .stop_seen(stop_seen)
    );

    // per-clock model of the line and flag rules
    logic en_prev = 1'b0;
    logic sda_drv_prev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!en_prev && (scl_drive_low || sda_drive_low || rx_full || stop_seen || rx_data != 8'h00))
                mon_err_r1++;
            if (sda_drive_low && !sda_drv_prev && scl_in)
                mon_err_r10++;
        end
        en_prev      = rx_enable;
        sda_drv_prev = sda_drive_low;
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up(output int held);
        m_scl = 1'b1;
        held  = 0;
        @(negedge clk);
        while (!scl_in) begin
            held++;
            if (held == 40) begin
                stretch_data = rx_data;
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic start_c();
        m_sda = 1'b1; wait_n(H);
        m_scl = 1'b1; wait_n(H);
        m_sda = 1'b0; wait_n(H);
        m_scl = 1'b0; wait_n(H);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wait_n(H);
        m_scl = 1'b1; wait_n(H);
        m_sda = 1'b1; wait_n(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        int h;
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_n(H);
            scl_up(h);    wait_n(H);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit flip_ack);
        int h;
        stretch_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_n(H);
            scl_up(h);
            if (h > 8) stretch_seen = 1'b1;
            wait_n(H);
            if (flip_ack && i == 7) ack_level = ~ack_level;
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wait_n(H);
        scl_up(h);
        if (h > 8) stretch_seen = 1'b1;
        wait_n(H / 2);
        acked = !sda_in;
        wait_n(H / 2);
        m_scl = 1'b0; wait_n(H);
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        check_eq({req, " rx_full before read"}, rx_full, 1);
        check_eq({req, " rx_data"}, rx_data, exp);
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        check_eq("R7 rx_full cleared by read", rx_full, 0);
    endtask

    task automatic clear_stop();
        stop_clear = 1'b1; @(negedge clk); stop_clear = 1'b0; @(negedge clk);
        check_eq("R8 stop_seen cleared", stop_seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        check_eq("R1 reset drives", {scl_drive_low, sda_drive_low}, 0);
        check_eq("R1 reset flags", {rx_full, stop_seen}, 0);
        check_eq("R1 reset data", rx_data, 0);

        // R1: disabled engine ignores a matching write
        start_c();
        send_byte({MY_ADDR, 1'b0}, 1'b0);
        check_eq("R1 no ack while disabled", acked, 0);
        check_eq("R1 rx_full while disabled", rx_full, 0);
        stop_c();
        check_eq("R1 stop_seen while disabled", stop_seen, 0);
        rx_enable = 1'b1;
        wait_n(4);

        // R2 address match + dummy read
        start_c();
        send_byte({MY_ADDR, 1'b0}, 1'b0);
        check_eq("R2 address acked", acked, 1);
        host_read({MY_ADDR, 1'b0}, "R2");

        // R4 data byte, R6 no stretch when empty
        send_byte(8'hC3, 1'b0);
        check_eq("R4 data acked", acked, 1);
        check_eq("R6 no stretch when empty", stretch_seen, 0);
        check_eq("R4 rx_full", rx_full, 1);
        check_eq("R4 rx_data", rx_data, 8'hC3);

        // R6 stretch while previous byte unread
        send_byte(8'h5A, 1'b0);
        check_eq("R6 stretch seen", stretch_seen, 1);
        check_eq("R6 data read during stretch", stretch_data, 8'hC3);
        check_eq("R5 ack during stretched byte", acked, 1);
        host_read(8'h5A, "R4");

        // R5 ack level latched per frame
        send_byte(8'h81, 1'b1);
        check_eq("R5 mid-frame change ignored", acked, 1);
        host_read(8'h81, "R4");
        send_byte(8'h7E, 1'b0);
        check_eq("R5 nack on next frame", acked, 0);
        host_read(8'h7E, "R4");
        ack_level = 1'b0;
        send_byte(8'h11, 1'b0);
        check_eq("R5 ack restored", acked, 1);
        host_read(8'h11, "R4");

        // R8 stop
        stop_c();
        check_eq("R8 stop_seen set", stop_seen, 1);
        check_eq("R8 lines released", {scl_drive_low, sda_drive_low}, 0);
        clear_stop();

        // R3 mismatch
        start_c();
        send_byte(8'h26, 1'b0);
        check_eq("R3 mismatch not acked", acked, 0);
        check_eq("R3 mismatch rx_full", rx_full, 0);
        send_byte(8'h00, 1'b0);
        check_eq("R3 later byte not acked", acked, 0);
        check_eq("R3 later byte rx_full", rx_full, 0);
        stop_c();
        clear_stop();

        // R3 read direction
        start_c();
        send_byte({MY_ADDR, 1'b1}, 1'b0);
        check_eq("R3 read direction not acked", acked, 0);
        check_eq("R3 read direction rx_full", rx_full, 0);
        stop_c();
        clear_stop();

        // R9 repeated START mid-byte
        start_c();
        send_byte({MY_ADDR, 1'b0}, 1'b0);
        host_read({MY_ADDR, 1'b0}, "R2");
        send_bits(8'hF0, 3);
        start_c();
        send_byte({MY_ADDR, 1'b0}, 1'b0);
        check_eq("R9 address after restart acked", acked, 1);
        host_read({MY_ADDR, 1'b0}, "R9");
        stop_c();
        clear_stop();

        check_eq("R1 per-clock disabled monitor", mon_err_r1, 0);
        check_eq("R10 per-clock SDA drive monitor", mon_err_r10, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule